// File: doc/BRIEF.md
# Interrupt Flag and Enable Register Pair

This block holds the interrupt state of a small peripheral: seven flag bits that latch one-cycle set pulses from the peripheral's event sources, and seven enable bits that software controls. A byte-wide register port, with a single select line, reaches either register. Reads of the flag or enable register have no side effects. Writes to the flag register clear flags. Writes to the enable register set or clear enables; data bit 7 chooses which.

Three dedicated strobes carry the clearing side effects of reads of other registers, which are decoded elsewhere. The first comes from the shift-register data read. The other two come from the low-byte counter reads of the two timers. Only the two timer flags and the shift-register flag can raise the registered level interrupt output.

Flag and enable bit positions: bit 0 and bit 1 are general edge sources A and B, bit 2 is the shift register, bit 3 is edge source C, bit 4 is edge source D, bit 5 is timer 2 and bit 6 is timer 1. Bit 7 of either register is never stored.

Top module: `intr_flag_enable`

## Requirements
- R1: After reset all flags and all enables are 0, the flag read returns 0x00, the enable read returns 0x80 and `irq` is 0.
- R2: A write to the enable register (`reg_sel`=1) with data bit 7 set ORs data bits 6..0 into the enables.
- R3: A write to the enable register with data bit 7 clear clears every enable whose data bit (6..0) is 1 and leaves the others unchanged.
- R4: Reading the enable register returns bit 7 as 1 and the seven enables in bits 6..0.
- R5: Reading the flag register (`reg_sel`=0) returns the seven flags in bits 6..0. Bit 7 is 1 exactly when some flag is both set and enabled, over all seven bits.
- R6: A write to the flag register clears every flag whose data bit (6..0) is 1. Data bits of 0, and data bit 7, leave flags unchanged.
- R7: `shift_rd_clr` clears flag bits 2, 3 and 4 together in one cycle.
- R8: `t1_lo_rd_clr` clears flag bit 6 and `t2_lo_rd_clr` clears flag bit 5.
- R9: A `set_pulse` bit sets its flag at the next clock, and the flag holds until it is cleared. When a set and any clear reach the same flag in one cycle, the flag ends up set.
- R10: `irq` is registered. In each cycle it equals, one clock late, whether flags AND enables is nonzero over bits 6, 5 and 2 only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the flag register, 1 selects the enable register |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the selected register (combinational) |
| set_pulse | input | 7 | Per-source one-cycle set pulses, bit positions as listed above |
| shift_rd_clr | input | 1 | Side-effect clear from the shift-register data read |
| t1_lo_rd_clr | input | 1 | Side-effect clear from the timer 1 low counter read |
| t2_lo_rd_clr | input | 1 | Side-effect clear from the timer 2 low counter read |
| irq | output | 1 | Registered level interrupt request |

## Verification
Directed cases first enable only the timer and shift sources, then mix in enables of the edge sources. This separates the read summary bit, which covers all seven bits, from `irq`, which covers three. Each strobe is tried on a flag word with neighbouring bits set, so a strobe that clears too much or too little shows. Collisions put a set pulse against a write-one-to-clear and against a read strobe on the same bit, to show which side wins. A long seeded random run then mixes writes in both enable modes, overlapping pulses and strobes. It compares the read data and the one-cycle-late `irq` against a bench model after every clock.

// File: rtl/intr_flag_pkg.sv
package intr_flag_pkg;
    localparam int SRC_W = 7;

    localparam int BIT_EDGE_A = 0;
    localparam int BIT_EDGE_B = 1;
    localparam int BIT_SHIFT  = 2;
    localparam int BIT_EDGE_C = 3;
    localparam int BIT_EDGE_D = 4;
    localparam int BIT_TMR2   = 5;
    localparam int BIT_TMR1   = 6;

    typedef logic [SRC_W-1:0] src_vec_t;

    // sources allowed to drive the interrupt line
    localparam src_vec_t IRQ_SRC_DEFAULT =
        src_vec_t'((1 << BIT_TMR1) | (1 << BIT_TMR2) | (1 << BIT_SHIFT));

    // flags cleared by the shift-register data read
    localparam src_vec_t SHIFT_RD_GROUP =
        src_vec_t'((1 << BIT_SHIFT) | (1 << BIT_EDGE_C) | (1 << BIT_EDGE_D));
endpackage

// File: rtl/intr_flag_bank.sv
module intr_flag_bank #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] flags_o
);
    logic [W-1:0] flags_q;

    // set has priority over every clear source
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= (flags_q & ~clr_i) | set_i;
    end

    assign flags_o = flags_q;

    // R9: a pulse always lands, even against a clear
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((flags_o & $past(set_i)) == $past(set_i)));

    // R6: a clear without a competing set empties the bit
    a_r6_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_i & ~set_i)) |=> ((flags_o & $past(clr_i & ~set_i)) == '0));

    // R9: with no set and no clear the flags hold
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i == '0 && clr_i == '0) |=> $stable(flags_o));
endmodule

// File: rtl/intr_enable_bank.sv
module intr_enable_bank #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic         mode_set_i,
    input  logic [W-1:0] bits_i,
    output logic [W-1:0] en_o
);
    logic [W-1:0] en_q;
    logic [W-1:0] en_d;

    always_comb begin
        en_d = en_q;
        if (wr_i) begin
            if (mode_set_i) en_d = en_q | bits_i;
            else            en_d = en_q & ~bits_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= en_d;
    end

    assign en_o = en_q;

    // R2: set mode turns on every addressed enable
    a_r2_set_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && mode_set_i) |=> ((en_o & $past(bits_i)) == $past(bits_i)));

    // R3: clear mode turns off every addressed enable, others untouched
    a_r3_clear_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !mode_set_i) |=>
            ((en_o & $past(bits_i)) == '0 &&
             (en_o & ~$past(bits_i)) == ($past(en_o) & ~$past(bits_i))));

    // R2/R3: no write keeps enables stable
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(en_o));
endmodule

// File: rtl/intr_irq_out.sv
module intr_irq_out #(
    parameter int           W    = 7,
    parameter logic [W-1:0] MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] flags_i,
    input  logic [W-1:0] en_i,
    output logic         irq_o
);
    logic irq_q;

    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(flags_i & en_i & MASK);
    end

    assign irq_o = irq_q;

    // R10: output follows the masked pending set one clock later
    a_r10_irq_late: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_o == (|($past(flags_i) & $past(en_i) & MASK))));

    // R10: sources outside the mask never raise the line
    a_r10_mask_only: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags_i & en_i & MASK) == '0) |=> !irq_o);
endmodule

// File: rtl/intr_flag_enable.sv
module intr_flag_enable
    import intr_flag_pkg::*;
#(
    parameter src_vec_t IRQ_SRC = IRQ_SRC_DEFAULT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             reg_sel,
    input  logic [7:0]       wdata,
    output logic [7:0]       rdata,
    input  logic [SRC_W-1:0] set_pulse,
    input  logic             shift_rd_clr,
    input  logic             t1_lo_rd_clr,
    input  logic             t2_lo_rd_clr,
    output logic             irq
);
    localparam logic SEL_FLAG = 1'b0;

    src_vec_t flags;
    src_vec_t enables;
    src_vec_t clr_vec;
    logic     wr_flag;
    logic     wr_enab;
    logic     pending_any;

    assign wr_flag = wr_en && (reg_sel == SEL_FLAG);
    assign wr_enab = wr_en && (reg_sel != SEL_FLAG);

    always_comb begin
        clr_vec = '0;
        if (wr_flag)      clr_vec = clr_vec | wdata[SRC_W-1:0];
        if (shift_rd_clr) clr_vec = clr_vec | SHIFT_RD_GROUP;
        if (t1_lo_rd_clr) clr_vec[BIT_TMR1] = 1'b1;
        if (t2_lo_rd_clr) clr_vec[BIT_TMR2] = 1'b1;
    end

    intr_flag_bank #(.W(SRC_W)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (set_pulse),
        .clr_i   (clr_vec),
        .flags_o (flags)
    );

    intr_enable_bank #(.W(SRC_W)) u_enables (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (wr_enab),
        .mode_set_i (wdata[7]),
        .bits_i     (wdata[SRC_W-1:0]),
        .en_o       (enables)
    );

    intr_irq_out #(.W(SRC_W), .MASK(IRQ_SRC)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .flags_i (flags),
        .en_i    (enables),
        .irq_o   (irq)
    );

    assign pending_any = |(flags & enables);

    always_comb begin
        if (reg_sel == SEL_FLAG) rdata = {pending_any, flags};
        else                     rdata = {1'b1, enables};
    end

    // R4: enable read always shows bit 7 high
    a_r4_enable_top: assert property (@(posedge clk) disable iff (!rst_n)
        reg_sel |-> rdata[7]);

    // R7: shift read strobe empties its group unless a pulse lands
    a_r7_shift_group: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_rd_clr && ((set_pulse & SHIFT_RD_GROUP) == '0)) |=>
            ((flags & SHIFT_RD_GROUP) == '0));

    // R8: timer 1 low read clears timer 1 flag unless re-set
    a_r8_t1_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (t1_lo_rd_clr && !set_pulse[BIT_TMR1]) |=> !flags[BIT_TMR1]);

    // R8: timer 2 low read clears timer 2 flag unless re-set
    a_r8_t2_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (t2_lo_rd_clr && !set_pulse[BIT_TMR2]) |=> !flags[BIT_TMR2]);

    // R1: state is empty in the first cycle after reset
    a_r1_reset_empty: assert property (@(posedge clk)
        !rst_n |=> (flags == '0 && enables == '0 && !irq));
endmodule

// File: tb/intr_flag_enable_test.sv
`timescale 1ns/1ps
module intr_flag_enable_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       reg_sel = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [6:0] set_pulse = 7'h00;
    logic       shift_rd_clr = 1'b0;
    logic       t1_lo_rd_clr = 1'b0;
    logic       t2_lo_rd_clr = 1'b0;
    logic       irq;

    int n_checks = 0;
    int n_fails  = 0;

    logic [6:0] m_flags = 7'h00;
    logic [6:0] m_en    = 7'h00;
    logic       m_irq   = 1'b0;

    localparam logic [6:0] IRQ_BITS   = 7'b1100100;
    localparam logic [6:0] SHIFT_BITS = 7'b0011100;

    always #2.5 clk = ~clk;

    intr_flag_enable uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_sel(reg_sel),
        .wdata(wdata), .rdata(rdata), .set_pulse(set_pulse),
        .shift_rd_clr(shift_rd_clr), .t1_lo_rd_clr(t1_lo_rd_clr),
        .t2_lo_rd_clr(t2_lo_rd_clr), .irq(irq)
    );

    function automatic logic [7:0] exp_rd(input logic sel);
        if (sel) return {1'b1, m_en};
        return {|(m_flags & m_en), m_flags};
    endfunction

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    task automatic cycle(input string req, input logic wr, input logic sel,
                         input logic [7:0] wd, input logic [6:0] sp,
                         input logic sh, input logic c1, input logic c2);
        logic [6:0] clr;
        @(negedge clk);
        wr_en = wr; reg_sel = sel; wdata = wd; set_pulse = sp;
        shift_rd_clr = sh; t1_lo_rd_clr = c1; t2_lo_rd_clr = c2;
        clr = 7'h00;
        if (wr && !sel) clr = clr | wd[6:0];
        if (sh) clr = clr | SHIFT_BITS;
        if (c1) clr[6] = 1'b1;
        if (c2) clr[5] = 1'b1;
        m_irq = |(m_flags & m_en & IRQ_BITS);
        m_flags = (m_flags & ~clr) | sp;
        if (wr && sel) m_en = wd[7] ? (m_en | wd[6:0]) : (m_en & ~wd[6:0]);
        @(posedge clk);
        #1;
        check(req, "rdata", rdata, exp_rd(sel));
        check(req, "irq", {7'h00, irq}, {7'h00, m_irq});
        @(negedge clk);
        wr_en = 1'b0; set_pulse = 7'h00;
        shift_rd_clr = 1'b0; t1_lo_rd_clr = 1'b0; t2_lo_rd_clr = 1'b0;
    endtask

    initial begin
        #(5.0 * 150000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'h1f2e3d4c);
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state at the ports
        reg_sel = 1'b0; #1;
        check("R1", "flag read", rdata, 8'h00);
        reg_sel = 1'b1; #1;
        check("R1", "enable read", rdata, 8'h80);
        check("R1", "irq", {7'h00, irq}, 8'h00);

        // R2 / R4: set timer1, timer2, shift enables
        cycle("R2", 1, 1, 8'hE4, 7'h00, 0, 0, 0);
        check("R4", "enable read", rdata, 8'hE4);
        // R9: timer 1 pulse latches, R10: irq one clock later
        cycle("R9", 0, 0, 8'h00, 7'h40, 0, 0, 0);
        check("R5", "summary", rdata, 8'hC0);
        check("R10", "irq not yet", {7'h00, irq}, 8'h00);
        cycle("R10", 0, 0, 8'h00, 7'h00, 0, 0, 0);
        check("R10", "irq high", {7'h00, irq}, 8'h01);
        // R3: clear timer 1 enable, other enables stay
        cycle("R3", 1, 1, 8'h40, 7'h00, 0, 0, 0);
        check("R3", "enables", rdata, 8'hA4);
        cycle("R10", 0, 0, 8'h00, 7'h00, 0, 0, 0);
        check("R10", "irq drops", {7'h00, irq}, 8'h00);
        // R5 / R10: edge source B enabled: summary yes, irq no
        cycle("R2", 1, 1, 8'h82, 7'h02, 0, 0, 0);
        cycle("R5", 0, 0, 8'h00, 7'h00, 0, 0, 0);
        check("R5", "summary edge B", rdata, 8'hC2);
        check("R10", "edge B masked", {7'h00, irq}, 8'h00);
        // R6: write-one-to-clear with bit 7 set, zeros keep
        cycle("R6", 1, 0, 8'hC0, 7'h00, 0, 0, 0);
        check("R6", "timer1 cleared, B kept", rdata, 8'h82);
        // R9: set against write clear on same bit
        cycle("R9", 1, 0, 8'h02, 7'h02, 0, 0, 0);
        check("R9", "set beats write clear", rdata, 8'h82);
        // R7: shift strobe clears bits 2..4 only
        cycle("R7", 0, 0, 8'h00, 7'h7F, 0, 0, 0);
        cycle("R7", 0, 0, 8'h00, 7'h00, 1, 0, 0);
        check("R7", "shift group cleared", rdata, 8'hE3);
        // R8: timer strobes
        cycle("R8", 0, 0, 8'h00, 7'h00, 0, 1, 0);
        check("R8", "timer1 cleared", rdata, 8'hA3);
        cycle("R8", 0, 0, 8'h00, 7'h00, 0, 0, 1);
        check("R8", "timer2 cleared", rdata, 8'h83);
        // R9: set against timer strobe
        cycle("R9", 0, 0, 8'h00, 7'h20, 0, 0, 1);
        check("R9", "set beats strobe", rdata, 8'hA3);
        // R9: set against shift strobe
        cycle("R9", 0, 0, 8'h00, 7'h08, 1, 0, 0);
        check("R9", "set beats shift strobe", rdata, 8'hAB);

        // R10 and all others: seeded random mix
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] wd;
            logic [6:0] sp;
            wd = 8'($urandom);
            sp = 7'($urandom) & 7'($urandom);
            cycle("R10", ($urandom % 4) == 0, 1'($urandom), wd, sp,
                  ($urandom % 8) == 0, ($urandom % 8) == 0, ($urandom % 8) == 0);
        end

        // R1: reset in the middle of activity
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk); #1;
        @(negedge clk);
        rst_n = 1'b1;
        reg_sel = 1'b0; #1;
        check("R1", "flags after reset", rdata, 8'h00);
        reg_sel = 1'b1; #1;
        check("R1", "enables after reset", rdata, 8'h80);
        check("R1", "irq after reset", {7'h00, irq}, 8'h00);

        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end
endmodule